// File: doc/BRIEF.md
# Return Address Stack Predictor

This block sits beside an instruction-fetch stage and predicts where a procedure return will go. Each cycle that fetch presents a valid 32-bit instruction word with its address, the block decodes the word and sorts it into one of three kinds: a procedure call, a procedure return, or neither. Calls push a return address onto a small circular stack. Returns pop the top entry, and on the following cycle the block offers that entry as the predicted next fetch address, together with a valid flag.

Calls and returns are recognised from how registers are used, not from dedicated opcodes. A return is either a load into the PC whose base register is the stack pointer, or a register move or ALU operation that writes the PC from the link register. A move of the PC into the link register arms a pending call. The next branch then pushes that captured value, so older call sequences built from two instructions are also tracked.

A global enable turns the whole predictor off. While it is low, the stack and the pending-call state do not change and no prediction is made.

Top module: `ras_predictor`

## Requirements
- R1: A fetched word with bits[27:25]=101, bit24=1 and bits[31:28] not 1111 (branch with link) pushes its own address plus 4.
- R2: A fetched word with bits[31:25]=1111101 (branch with link and exchange, immediate) pushes its own address plus 4.
- R3: A word with bits[27:26]=01, bit20=1, bits[15:12]=1111 and bits[19:16]=1101 (single load to PC via the stack pointer) pops the stack. On the cycle after the fetch strobe, pred_vld_o is 1 and pred_tgt_o holds the popped address.
- R4: A word with bits[27:25]=100, bit20=1, bit15=1 and bits[19:16]=1101 (block load including PC via the stack pointer) pops and predicts in the same way as R3.
- R5: A word with bits[27:26]=00, bit25=0, bits[15:12]=1111 and bits[3:0]=1110 (register operation writing PC from the link register) pops and predicts in the same way as R3.
- R6: The stack holds 8 entries and is last-in first-out. A push while full overwrites the oldest entry, so after N pushes only the last min(N,8) are returned, newest first.
- R7: A return while the stack is empty gives pred_vld_o=0 and leaves the stack pointer unchanged, so later pushes and pops still pair correctly.
- R8: A word with bits[27:26]=00, bit25=0, bits[15:12]=1110 and bits[3:0]=1111 (PC copied into the link register) arms a pending call holding its address plus 8. The next branch (bits[27:25]=101) clears the pending call. If that branch is not itself a call, it pushes the held value.
- R9: A call of the R1 or R2 kind that arrives while a call is pending pushes only its own address plus 4. The pending value is discarded.
- R10: While en_i is 0, pred_vld_o stays 0, and the stack and the pending call are neither changed nor consumed.
- R11: pred_vld_o is asserted only on the cycle after a fetch strobe that carried a return, and for one cycle only. Words presented without fetch_vld_i have no effect.
- R12: Reset empties the stack, clears any pending call and drives pred_vld_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Global predictor enable |
| fetch_vld_i | input | 1 | Fetched word and address are valid this cycle |
| instr_i | input | 32 | Fetched instruction word |
| pc_i | input | 32 | Address of the fetched word |
| pred_vld_o | output | 1 | Predicted return target is valid |
| pred_tgt_o | output | 32 | Predicted return target |

## Verification
Two functions can fall in the same cycle: pushing a call's own return address and discarding an armed pending call. The bench provokes this by arming a pending call with a PC-to-link-register move, following it with a branch with link at a different address, and then sending a plain branch. It then pops three times. The first pop must give the call's own address plus 4, the second the older entry beneath it, and the third must give no prediction. That result shows the pending value was neither pushed nor left armed for the later plain branch. The capacity sweep also makes overwrite and order meet, by pushing up to ten entries into the eight-entry stack.

// File: rtl/ras_pkg.sv
package ras_pkg;

  // Classification of one fetched word
  typedef struct packed {
    logic call;     // branch with link (either form)
    logic ret;      // return through SP load or PC-from-LR operation
    logic prelude;  // PC copied into LR: arms a pending call
    logic branch;   // any immediate branch, with or without link
  } ras_cls_t;

  localparam logic [2:0] ENC_BRANCH = 3'b101;
  localparam logic [2:0] ENC_BLOCK  = 3'b100;
  localparam logic [1:0] ENC_SINGLE = 2'b01;
  localparam logic [1:0] ENC_DATAOP = 2'b00;
  localparam logic [6:0] ENC_BLXIMM = 7'b1111101;
  localparam logic [3:0] REG_SP     = 4'd13;
  localparam logic [3:0] REG_LR     = 4'd14;
  localparam logic [3:0] REG_PC     = 4'd15;
  localparam logic [3:0] COND_NV    = 4'b1111;

endpackage

// File: rtl/ras_decoder.sv
module ras_decoder
  import ras_pkg::*;
(
  input  logic [31:0] instr_i,
  output ras_cls_t    cls_o
);

  logic is_bl, is_blx, is_br;
  logic ld_single, ld_block, dp_ret, dp_link;
  logic unused_bits;

  always_comb begin
    is_br     = (instr_i[27:25] == ENC_BRANCH);
    is_bl     = is_br && instr_i[24] && (instr_i[31:28] != COND_NV);
    is_blx    = (instr_i[31:25] == ENC_BLXIMM);
    ld_single = (instr_i[27:26] == ENC_SINGLE) && instr_i[20] &&
                (instr_i[15:12] == REG_PC) && (instr_i[19:16] == REG_SP);
    ld_block  = (instr_i[27:25] == ENC_BLOCK) && instr_i[20] &&
                instr_i[15] && (instr_i[19:16] == REG_SP);
    dp_ret    = (instr_i[27:26] == ENC_DATAOP) && !instr_i[25] &&
                (instr_i[15:12] == REG_PC) && (instr_i[3:0] == REG_LR);
    dp_link   = (instr_i[27:26] == ENC_DATAOP) && !instr_i[25] &&
                (instr_i[15:12] == REG_LR) && (instr_i[3:0] == REG_PC);

    cls_o.call    = is_bl || is_blx;
    cls_o.ret     = ld_single || ld_block || dp_ret;
    cls_o.prelude = dp_link;
    cls_o.branch  = is_br;
  end

  assign unused_bits = ^{instr_i[23:21], instr_i[14:4]};

endmodule

// File: rtl/ras_pending.sv
module ras_pending #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_i,
  input  logic          prelude_i,
  input  logic          branch_i,
  input  logic [AW-1:0] pc_i,
  output logic          pend_vld_o,
  output logic [AW-1:0] pend_addr_o
);

  localparam logic [AW-1:0] LINK_OFS = AW'(8);

  logic          pend_q, pend_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          addr_en;

  always_comb begin
    pend_d  = pend_q;
    addr_d  = addr_q;
    addr_en = 1'b0;
    if (act_i && prelude_i) begin
      pend_d  = 1'b1;
      addr_d  = pc_i + LINK_OFS;
      addr_en = 1'b1;
    end else if (act_i && branch_i) begin
      pend_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign pend_vld_o  = pend_q;
  assign pend_addr_o = addr_q;

  assert_pend_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i && branch_i) |=> !pend_q);

  assert_pend_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !act_i |=> $stable(pend_q));

endmodule

// File: rtl/ras_stack.sv
module ras_stack #(
  parameter int AW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic          pop_i,
  output logic          top_vld_o,
  output logic [AW-1:0] top_addr_o
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [PTR_W-1:0] ptr_q, ptr_d, ptr_inc, ptr_dec;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             empty, full, do_pop;
  logic [DEPTH-1:0] wr_en;
  logic [AW-1:0]    rd_ent [DEPTH];

  always_comb begin
    empty   = (cnt_q == '0);
    full    = (cnt_q == CNT_FULL);
    do_pop  = pop_i && !empty;
    ptr_inc = (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
    ptr_dec = (ptr_q == '0) ? PTR_LAST : ptr_q - 1'b1;
    ptr_d   = ptr_q;
    cnt_d   = cnt_q;
    if (push_i) begin
      ptr_d = ptr_inc;
      if (!full) cnt_d = cnt_q + 1'b1;
    end else if (do_pop) begin
      ptr_d = ptr_dec;
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [AW-1:0] ent_q;
    assign wr_en[g] = push_i && (ptr_inc == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (wr_en[g]) ent_q <= push_addr_i;
    end
    assign rd_ent[g] = ent_q;
  end

  assign top_vld_o  = !empty;
  assign top_addr_o = rd_ent[ptr_q];

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);

  assert_push_grow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && cnt_q != CNT_FULL) |=> cnt_q == $past(cnt_q) + 1'b1);

  assert_empty_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && cnt_q == '0) |=> ($stable(ptr_q) && cnt_q == '0));

  assert_single_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));

endmodule

// File: rtl/ras_predictor.sv
module ras_predictor #(
  parameter int AW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          fetch_vld_i,
  input  logic [31:0]   instr_i,
  input  logic [AW-1:0] pc_i,
  output logic          pred_vld_o,
  output logic [AW-1:0] pred_tgt_o
);
  import ras_pkg::*;

  localparam logic [AW-1:0] CALL_OFS = AW'(4);

  ras_cls_t      cls;
  logic          act, push, pop;
  logic          pend_vld;
  logic [AW-1:0] pend_addr, push_addr;
  logic          top_vld;
  logic [AW-1:0] top_addr;
  logic          pvld_d;

  ras_decoder u_dec (
    .instr_i (instr_i),
    .cls_o   (cls)
  );

  ras_pending #(.AW(AW)) u_pend (
    .clk         (clk),
    .rst_n       (rst_n),
    .act_i       (act),
    .prelude_i   (cls.prelude),
    .branch_i    (cls.branch),
    .pc_i        (pc_i),
    .pend_vld_o  (pend_vld),
    .pend_addr_o (pend_addr)
  );

  always_comb begin
    act       = fetch_vld_i && en_i;
    push      = act && (cls.call || (cls.branch && pend_vld));
    push_addr = cls.call ? (pc_i + CALL_OFS) : pend_addr;
    pop       = act && cls.ret;
    pvld_d    = pop && top_vld;
  end

  ras_stack #(.AW(AW), .DEPTH(DEPTH)) u_stk (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push),
    .push_addr_i (push_addr),
    .pop_i       (pop),
    .top_vld_o   (top_vld),
    .top_addr_o  (top_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pred_vld_o <= 1'b0;
    else        pred_vld_o <= pvld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pred_tgt_o <= '0;
    else if (pvld_d) pred_tgt_o <= top_addr;
  end

  always_comb begin
    if (rst_n) assert_no_push_pop_R9: assert (!(push && pop));
  end

  assert_disable_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !pred_vld_o);

  assert_pred_after_fetch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pred_vld_o |-> $past(fetch_vld_i && en_i));

endmodule

// File: tb/ras_predictor_tb_top.sv
`timescale 1ns/1ps
module ras_predictor_tb_top;

  localparam logic [31:0] I_BL   = 32'hEB000000;
  localparam logic [31:0] I_BLX  = 32'hFA000000;
  localparam logic [31:0] I_B    = 32'hEA000000;
  localparam logic [31:0] I_LDR  = 32'hE49DF004;
  localparam logic [31:0] I_LDM  = 32'hE8BD8000;
  localparam logic [31:0] I_MOVR = 32'hE1A0F00E;
  localparam logic [31:0] I_LINK = 32'hE1A0E00F;
  localparam logic [31:0] I_NOP  = 32'hE1A00000;
  localparam logic [31:0] I_LDR0 = 32'hE490F004;

  logic        clk = 1'b0;
  logic        rst_n, en, fvld;
  logic [31:0] instr, pc;
  logic        pred_vld;
  logic [31:0] pred_tgt;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  ras_predictor dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en),
    .fetch_vld_i (fvld),
    .instr_i     (instr),
    .pc_i        (pc),
    .pred_vld_o  (pred_vld),
    .pred_tgt_o  (pred_tgt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    fvld  = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic fetch(input logic [31:0] w, input logic [31:0] a);
    @(negedge clk);
    instr = w;
    pc    = a;
    fvld  = 1'b1;
    @(negedge clk);
    fvld  = 1'b0;
  endtask

  // return fetch, then judge the registered prediction
  task automatic ret(input string req, input logic [31:0] w,
                     input logic ev, input logic [31:0] et);
    fetch(w, 32'h0000F000);
    chk(req, {31'd0, pred_vld}, {31'd0, ev});
    if (ev) chk(req, pred_tgt, et);
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b1; fvld = 1'b0; instr = '0; pc = '0;
    do_reset();

    // R12: reset state
    chk("R12", {31'd0, pred_vld}, 32'd0);

    // R1 with R3, R2 with R5, R4
    fetch(I_BL, 32'h1000);
    ret("R1/R3", I_LDR, 1'b1, 32'h1004);
    fetch(I_BLX, 32'h2000);
    ret("R2/R5", I_MOVR, 1'b1, 32'h2004);
    fetch(I_BL, 32'h3000);
    ret("R4", I_LDM, 1'b1, 32'h3004);

    // R11: prediction lasts one cycle; no strobe, no effect
    fetch(I_BL, 32'h3100);
    ret("R11", I_LDR, 1'b1, 32'h3104);
    @(negedge clk);
    chk("R11", {31'd0, pred_vld}, 32'd0);
    fetch(I_BL, 32'h3200);
    @(negedge clk); instr = I_LDR; fvld = 1'b0;
    @(negedge clk);
    chk("R11", {31'd0, pred_vld}, 32'd0);
    ret("R11", I_LDR, 1'b1, 32'h3204);

    // R7: empty pop, then pairing still correct
    ret("R7", I_LDR, 1'b0, 32'h0);
    ret("R7", I_MOVR, 1'b0, 32'h0);
    fetch(I_BL, 32'h4000);
    ret("R7", I_LDR, 1'b1, 32'h4004);
    ret("R7", I_LDR, 1'b0, 32'h0);

    // non-matching words do nothing
    fetch(I_BL, 32'h9000);
    fetch(I_NOP, 32'h9004);
    ret("R3", I_LDR0, 1'b0, 32'h0);
    ret("R1", I_LDR, 1'b1, 32'h9004);

    // R6: capacity and order sweep
    for (int n = 1; n <= 10; n++) begin
      do_reset();
      for (int k = 0; k < n; k++) fetch(I_BL, 32'h10000 + 32'(16 * k));
      for (int j = 0; j <= n; j++) begin
        if (j < ((n < 8) ? n : 8))
          ret("R6", (j % 2) ? I_LDM : I_MOVR, 1'b1, 32'h10000 + 32'(16 * (n - 1 - j)) + 32'h4);
        else
          ret("R6", I_LDR, 1'b0, 32'h0);
      end
    end

    // R8: prelude then plain branch pushes pc+8; second branch pushes nothing
    do_reset();
    fetch(I_LINK, 32'h5000);
    fetch(I_B, 32'h5004);
    fetch(I_B, 32'h6000);
    ret("R8", I_LDR, 1'b1, 32'h5008);
    ret("R8", I_LDR, 1'b0, 32'h0);

    // R9: call while pending pushes only its own return address
    fetch(I_BL, 32'h7000);
    fetch(I_LINK, 32'h7100);
    fetch(I_BL, 32'h7200);
    fetch(I_B, 32'h7300);
    ret("R9", I_LDR, 1'b1, 32'h7204);
    ret("R9", I_MOVR, 1'b1, 32'h7004);
    ret("R9", I_LDR, 1'b0, 32'h0);

    // R10: disable blocks push, pop and pending
    en = 1'b0;
    fetch(I_BL, 32'h8000);
    ret("R10", I_LDR, 1'b0, 32'h0);
    en = 1'b1;
    ret("R10", I_LDR, 1'b0, 32'h0);
    fetch(I_BL, 32'h8100);
    en = 1'b0;
    ret("R10", I_LDR, 1'b0, 32'h0);
    fetch(I_LINK, 32'h8200);
    en = 1'b1;
    fetch(I_B, 32'h8300);
    ret("R10", I_LDR, 1'b1, 32'h8104);
    ret("R10", I_LDR, 1'b0, 32'h0);

    // R12: reset drops stack and pending call
    fetch(I_BL, 32'hA000);
    fetch(I_LINK, 32'hA100);
    do_reset();
    fetch(I_B, 32'hA104);
    ret("R12", I_LDR, 1'b0, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule